// File: doc/BRIEF.md
# Register writer table with rollback history

This block keeps, for every architectural register, the identity of the function unit that will write it next. It is the unit issued most recently in program order. Issue logic asks it which unit a source operand is waiting on. Completion logic tells it when a unit has written back, so the dependency can be dropped. No physical renaming takes place. Each register keeps one name, and the table alone tracks who owns it.

Every issue also pushes a history record. The record holds the register's previous entry (valid bit and unit id) and is tagged with the newly issued unit. When an exception or interrupt cancels a set of in-flight units, a rollback command walks the history from newest to oldest. It puts back the previous entry of every record whose tag is cancelled, so the table returns to the state it had before those units issued. Records are discarded when their unit completes. A previous entry that names a completed unit is marked invalid, so a rollback never restores a dependency on a result that is already written. The history has a fixed depth, and issue stalls while it is full.

Top module: `writer_table`

## Requirements
- R1: After reset every register reads back invalid on the lookup port and `iss_ready` is 1.
- R2: The lookup port is combinational. In the same cycle, `lk_valid`/`lk_unit` show the current entry for `lk_reg`.
- R3: An accepted issue (`iss_valid` and `iss_ready` high at a clock edge) makes the entry of `iss_reg` valid with `iss_unit` from the next cycle on. It also adds one history record.
- R4: A completion clears a register entry only if that entry names `cmp_unit`. Other entries are unchanged, and a completion for a unit that names no entry has no visible effect.
- R5: When an issue and a completion share a cycle, the completion is applied first. The history record pushed by the issue therefore holds the entry as it stands after the completion.
- R6: A rollback (`rb_valid`, with bit u of `rb_mask` set for each cancelled unit id u) takes the history records from newest to oldest. For every record tagged with a cancelled unit, it writes that record's previous entry back into its register and removes the record.
- R7: On completion, all history records tagged with that unit are removed, and every stored previous entry naming that unit becomes invalid. A later rollback therefore restores "no pending writer" rather than the completed unit.
- R8: The history holds HIST_DEPTH records (default 8). While it is full `iss_ready` is 0 and an offered issue has no effect.
- R9: During a rollback cycle `iss_ready` is 0 and an offered issue is ignored. A completion in the same cycle is applied after the restore.
- R10: A rollback whose mask names only units that have no history record leaves every entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_reg | input | $clog2(NUM_REGS) | Destination register of the issuing instruction |
| iss_unit | input | $clog2(NUM_UNITS) | Function unit that will write it |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| cmp_valid | input | 1 | A unit has written back |
| cmp_unit | input | $clog2(NUM_UNITS) | Id of the completing unit |
| rb_valid | input | 1 | Rollback command |
| rb_mask | input | NUM_UNITS | One bit per cancelled unit id |
| lk_reg | input | $clog2(NUM_REGS) | Source register to look up |
| lk_valid | output | 1 | The looked-up register has a pending writer |
| lk_unit | output | $clog2(NUM_UNITS) | Id of that pending writer |

## Verification
A corrupted entry shows up on the lookup port in the very cycle it is read, so sweeping all registers after every clock edge catches it one cycle after the faulty update. A wrong history record stays hidden until a rollback reaches it. It then appears as a wrong or stale restored writer on the following sweep, which is why rollbacks are mixed in often and after completions of older units. A history count that drifts is seen through `iss_ready`, which goes low one issue early or late against the expected depth.

// File: rtl/wt_pkg.sv
package wt_pkg;

  // What becomes of one history slot in the current cycle.
  typedef enum logic [1:0] {
    REC_EMPTY  = 2'd0,
    REC_KEEP   = 2'd1,
    REC_DONE   = 2'd2,
    REC_CANCEL = 2'd3
  } rec_fate_e;

  // Cancellation wins over completion; an unused slot stays empty.
  function automatic rec_fate_e fate_of(input logic live, input logic done, input logic cancel);
    if (!live)  return REC_EMPTY;
    if (cancel) return REC_CANCEL;
    if (done)   return REC_DONE;
    return REC_KEEP;
  endfunction

  // A stored writer survives a completion unless it names the completing unit.
  function automatic logic still_pending(input logic v, input logic same_unit, input logic fire);
    return v && !(fire && same_unit);
  endfunction

endpackage

// File: rtl/wt_history.sv
module wt_history
  import wt_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int NUM_UNITS  = 8,
  parameter int HIST_DEPTH = 8,
  localparam int RW = $clog2(NUM_REGS),
  localparam int UW = $clog2(NUM_UNITS),
  localparam int AW = (HIST_DEPTH > 1) ? $clog2(HIST_DEPTH) : 1,
  localparam int CW = $clog2(HIST_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmp_fire,
  input  logic [UW-1:0]            cmp_unit,
  input  logic                     rb_fire,
  input  logic [NUM_UNITS-1:0]     rb_mask,
  input  logic                     push,
  input  logic [RW-1:0]            push_reg,
  input  logic [UW-1:0]            push_unit,
  input  logic                     push_prev_v,
  input  logic [UW-1:0]            push_prev_u,
  output logic [CW-1:0]            count,
  output logic                     full,
  output logic [NUM_REGS-1:0]      rst_hit,
  output logic [NUM_REGS-1:0]      rst_v,
  output logic [NUM_REGS-1:0][UW-1:0] rst_u
);

  logic [UW-1:0] h_tag [HIST_DEPTH];
  logic [RW-1:0] h_reg [HIST_DEPTH];
  logic          h_pv  [HIST_DEPTH];
  logic [UW-1:0] h_pu  [HIST_DEPTH];

  logic [UW-1:0] n_tag [HIST_DEPTH];
  logic [RW-1:0] n_reg [HIST_DEPTH];
  logic          n_pv  [HIST_DEPTH];
  logic [UW-1:0] n_pu  [HIST_DEPTH];
  logic [CW-1:0] n_count;

  assign full = (count == CW'(HIST_DEPTH));

  // Restore values: walk newest to oldest, so the oldest cancelled record wins.
  always_comb begin
    rst_hit = '0;
    rst_v   = '0;
    rst_u   = '0;
    for (int i = HIST_DEPTH - 1; i >= 0; i--) begin
      if ((CW'(i) < count) && rb_mask[h_tag[i]]) begin
        rst_hit[h_reg[i]] = 1'b1;
        rst_v[h_reg[i]]   = h_pv[i];
        rst_u[h_reg[i]]   = h_pu[i];
      end
    end
  end

  // Compaction: surviving records slide down in order, then the new one goes on top.
  always_comb begin
    logic [CW-1:0] wp;
    rec_fate_e     fate;
    wp = '0;
    for (int i = 0; i < HIST_DEPTH; i++) begin
      n_tag[i] = '0;
      n_reg[i] = '0;
      n_pv[i]  = 1'b0;
      n_pu[i]  = '0;
    end
    for (int i = 0; i < HIST_DEPTH; i++) begin
      fate = fate_of(CW'(i) < count,
                     cmp_fire && (h_tag[i] == cmp_unit),
                     rb_fire && rb_mask[h_tag[i]]);
      if (fate == REC_KEEP) begin
        n_tag[wp[AW-1:0]] = h_tag[i];
        n_reg[wp[AW-1:0]] = h_reg[i];
        n_pv[wp[AW-1:0]]  = still_pending(h_pv[i], h_pu[i] == cmp_unit, cmp_fire);
        n_pu[wp[AW-1:0]]  = h_pu[i];
        wp = wp + CW'(1);
      end
    end
    if (push) begin
      n_tag[wp[AW-1:0]] = push_unit;
      n_reg[wp[AW-1:0]] = push_reg;
      n_pv[wp[AW-1:0]]  = push_prev_v;
      n_pu[wp[AW-1:0]]  = push_prev_u;
      wp = wp + CW'(1);
    end
    n_count = wp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < HIST_DEPTH; i++) begin
        h_tag[i] <= '0;
        h_reg[i] <= '0;
        h_pv[i]  <= 1'b0;
        h_pu[i]  <= '0;
      end
    end else begin
      count <= n_count;
      for (int i = 0; i < HIST_DEPTH; i++) begin
        h_tag[i] <= n_tag[i];
        h_reg[i] <= n_reg[i];
        h_pv[i]  <= n_pv[i];
        h_pu[i]  <= n_pu[i];
      end
    end
  end

  // Checker state: last cycle's mask and completing unit.
  logic [NUM_UNITS-1:0] mask_q;
  logic [UW-1:0]        done_q;
  logic                 cancel_left;
  logic                 done_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      done_q <= '0;
    end else begin
      mask_q <= rb_mask;
      done_q <= cmp_unit;
    end
  end

  always_comb begin
    cancel_left = 1'b0;
    done_left   = 1'b0;
    for (int i = 0; i < HIST_DEPTH; i++) begin
      if (CW'(i) < count) begin
        if (mask_q[h_tag[i]])  cancel_left = 1'b1;
        if (h_tag[i] == done_q) done_left  = 1'b1;
      end
    end
  end

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(HIST_DEPTH));

  // R3
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !cmp_fire && !rb_fire) |=> (count == $past(count) + CW'(1)));

  // R6
  cancel_purge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_fire |=> !cancel_left);

  // R7
  done_purge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire && !(push && push_unit == cmp_unit)) |=> !done_left);

endmodule

// File: rtl/wt_entries.sv
module wt_entries
  import wt_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int NUM_UNITS = 8,
  localparam int RW = $clog2(NUM_REGS),
  localparam int UW = $clog2(NUM_UNITS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        iss_fire,
  input  logic [RW-1:0]               iss_reg,
  input  logic [UW-1:0]               iss_unit,
  input  logic                        cmp_fire,
  input  logic [UW-1:0]               cmp_unit,
  input  logic                        rb_fire,
  input  logic [NUM_REGS-1:0]         rst_hit,
  input  logic [NUM_REGS-1:0]         rst_v,
  input  logic [NUM_REGS-1:0][UW-1:0] rst_u,
  input  logic [RW-1:0]               lk_reg,
  output logic                        lk_valid,
  output logic [UW-1:0]               lk_unit,
  output logic                        prev_v,
  output logic [UW-1:0]               prev_u
);

  logic          ev [NUM_REGS];
  logic [UW-1:0] eu [NUM_REGS];
  logic          nv [NUM_REGS];
  logic [UW-1:0] nu [NUM_REGS];

  assign lk_valid = ev[lk_reg];
  assign lk_unit  = eu[lk_reg];

  // Entry of the issue target once this cycle's completion has been applied.
  assign prev_v = still_pending(ev[iss_reg], eu[iss_reg] == cmp_unit, cmp_fire);
  assign prev_u = eu[iss_reg];

  // Per register: restore, then completion, then issue.
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      nv[r] = ev[r];
      nu[r] = eu[r];
      if (rb_fire && rst_hit[r]) begin
        nv[r] = rst_v[r];
        nu[r] = rst_u[r];
      end
      nv[r] = still_pending(nv[r], nu[r] == cmp_unit, cmp_fire);
      if (iss_fire && (iss_reg == RW'(r))) begin
        nv[r] = 1'b1;
        nu[r] = iss_unit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        ev[r] <= 1'b0;
        eu[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        ev[r] <= nv[r];
        eu[r] <= nu[r];
      end
    end
  end

  // Checker: does any entry still name last cycle's completing unit?
  logic [UW-1:0] done_q;
  logic          named_done;

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= '0;
    else        done_q <= cmp_unit;
  end

  always_comb begin
    named_done = 1'b0;
    for (int r = 0; r < NUM_REGS; r++)
      if (ev[r] && eu[r] == done_q) named_done = 1'b1;
  end

  // R3
  install_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |=> (ev[$past(iss_reg)] && eu[$past(iss_reg)] == $past(iss_unit)));

  // R4
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire && !(iss_fire && iss_unit == cmp_unit)) |=> !named_done);

endmodule

// File: rtl/writer_table.sv
module writer_table #(
  parameter int NUM_REGS   = 16,
  parameter int NUM_UNITS  = 8,
  parameter int HIST_DEPTH = 8,
  localparam int RW = $clog2(NUM_REGS),
  localparam int UW = $clog2(NUM_UNITS),
  localparam int CW = $clog2(HIST_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iss_valid,
  input  logic [RW-1:0]        iss_reg,
  input  logic [UW-1:0]        iss_unit,
  output logic                 iss_ready,
  input  logic                 cmp_valid,
  input  logic [UW-1:0]        cmp_unit,
  input  logic                 rb_valid,
  input  logic [NUM_UNITS-1:0] rb_mask,
  input  logic [RW-1:0]        lk_reg,
  output logic                 lk_valid,
  output logic [UW-1:0]        lk_unit
);

  // Named internal events.
  logic                        issue_fire;
  logic                        cmp_fire;
  logic                        rb_fire;
  logic                        hist_full;
  logic [CW-1:0]               hist_count;
  logic                        prev_v;
  logic [UW-1:0]               prev_u;
  logic [NUM_REGS-1:0]         rst_hit;
  logic [NUM_REGS-1:0]         rst_v;
  logic [NUM_REGS-1:0][UW-1:0] rst_u;

  assign rb_fire    = rb_valid;
  assign cmp_fire   = cmp_valid;
  assign iss_ready  = !rb_valid && !hist_full;
  assign issue_fire = iss_valid && iss_ready;

  wt_history #(
    .NUM_REGS  (NUM_REGS),
    .NUM_UNITS (NUM_UNITS),
    .HIST_DEPTH(HIST_DEPTH)
  ) u_history (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_fire   (cmp_fire),
    .cmp_unit   (cmp_unit),
    .rb_fire    (rb_fire),
    .rb_mask    (rb_mask),
    .push       (issue_fire),
    .push_reg   (iss_reg),
    .push_unit  (iss_unit),
    .push_prev_v(prev_v),
    .push_prev_u(prev_u),
    .count      (hist_count),
    .full       (hist_full),
    .rst_hit    (rst_hit),
    .rst_v      (rst_v),
    .rst_u      (rst_u)
  );

  wt_entries #(
    .NUM_REGS (NUM_REGS),
    .NUM_UNITS(NUM_UNITS)
  ) u_entries (
    .clk     (clk),
    .rst_n   (rst_n),
    .iss_fire(issue_fire),
    .iss_reg (iss_reg),
    .iss_unit(iss_unit),
    .cmp_fire(cmp_fire),
    .cmp_unit(cmp_unit),
    .rb_fire (rb_fire),
    .rst_hit (rst_hit),
    .rst_v   (rst_v),
    .rst_u   (rst_u),
    .lk_reg  (lk_reg),
    .lk_valid(lk_valid),
    .lk_unit (lk_unit),
    .prev_v  (prev_v),
    .prev_u  (prev_u)
  );

  // R9
  rb_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |=> (hist_count <= $past(hist_count)));

  // R8
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_full && !rb_valid && !cmp_valid) |=> (hist_count == $past(hist_count)));

endmodule

// File: tb/writer_table_bench.sv
`timescale 1ns/1ps
module writer_table_bench;

  localparam int NR = 16;
  localparam int NU = 8;
  localparam int HD = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid = 1'b0;
  logic [3:0]    iss_reg = '0;
  logic [2:0]    iss_unit = '0;
  logic          iss_ready;
  logic          cmp_valid = 1'b0;
  logic [2:0]    cmp_unit = '0;
  logic          rb_valid = 1'b0;
  logic [NU-1:0] rb_mask = '0;
  logic [3:0]    lk_reg = '0;
  logic          lk_valid;
  logic [2:0]    lk_unit;

  always #4 clk = ~clk;

  writer_table #(.NUM_REGS(NR), .NUM_UNITS(NU), .HIST_DEPTH(HD)) u_writer_table (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_reg(iss_reg), .iss_unit(iss_unit), .iss_ready(iss_ready),
    .cmp_valid(cmp_valid), .cmp_unit(cmp_unit),
    .rb_valid(rb_valid), .rb_mask(rb_mask),
    .lk_reg(lk_reg), .lk_valid(lk_valid), .lk_unit(lk_unit)
  );

  int total = 0;
  int fails = 0;
  bit done  = 0;

  // Reference state: table and an ordered record list, oldest first.
  bit       m_v [NR];
  int       m_u [NR];
  int       r_tag [HD];
  int       r_reg [HD];
  bit       r_pv  [HD];
  int       r_pu  [HD];
  int       r_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_ready(input bit rb);
    return !rb && (r_cnt < HD);
  endfunction

  function automatic bit unit_busy(input int u);
    for (int i = 0; i < r_cnt; i++) if (r_tag[i] == u) return 1;
    return 0;
  endfunction

  task automatic model_drop(input int i);
    for (int k = i; k < r_cnt - 1; k++) begin
      r_tag[k] = r_tag[k+1]; r_reg[k] = r_reg[k+1];
      r_pv[k]  = r_pv[k+1];  r_pu[k]  = r_pu[k+1];
    end
    r_cnt--;
  endtask

  task automatic model_apply(input bit iv, input int rg, input int un,
                             input bit cv, input int cu, input bit rv, input bit [NU-1:0] mk);
    bit take;
    take = iv && exp_ready(rv);
    if (rv) begin
      for (int i = r_cnt - 1; i >= 0; i--)
        if (mk[r_tag[i]]) begin
          m_v[r_reg[i]] = r_pv[i];
          m_u[r_reg[i]] = r_pu[i];
        end
      for (int i = r_cnt - 1; i >= 0; i--)
        if (mk[r_tag[i]]) model_drop(i);
    end
    if (cv) begin
      for (int r = 0; r < NR; r++) if (m_v[r] && m_u[r] == cu) m_v[r] = 0;
      for (int i = r_cnt - 1; i >= 0; i--) if (r_tag[i] == cu) model_drop(i);
      for (int i = 0; i < r_cnt; i++) if (r_pu[i] == cu) r_pv[i] = 0;
    end
    if (take) begin
      r_tag[r_cnt] = un; r_reg[r_cnt] = rg;
      r_pv[r_cnt]  = m_v[rg]; r_pu[r_cnt] = m_u[rg];
      r_cnt++;
      m_v[rg] = 1; m_u[rg] = un;
    end
  endtask

  task automatic sweep(input string req);
    for (int r = 0; r < NR; r++) begin
      lk_reg = 4'(r);
      #0.2;
      chk(lk_valid == m_v[r], req, lk_valid, m_v[r]);
      if (m_v[r]) chk(lk_unit == 3'(m_u[r]), req, lk_unit, m_u[r]);
    end
  endtask

  // One cycle: drive, check ready before the edge, update model, sweep after.
  task automatic step(input bit iv, input int rg, input int un,
                      input bit cv, input int cu, input bit rv, input bit [NU-1:0] mk,
                      input string req);
    iss_valid = iv; iss_reg = 4'(rg); iss_unit = 3'(un);
    cmp_valid = cv; cmp_unit = 3'(cu);
    rb_valid  = rv; rb_mask = mk;
    #1;
    chk(iss_ready == exp_ready(rv), {req, " ready"}, iss_ready, exp_ready(rv));
    @(posedge clk);
    model_apply(iv, rg, un, cv, cu, rv, mk);
    #1;
    iss_valid = 0; cmp_valid = 0; rb_valid = 0;
    sweep(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int seed;
    bit [NU-1:0] mk;
    seed = $urandom(32'h5eed_1234);
    for (int r = 0; r < NR; r++) begin m_v[r] = 0; m_u[r] = 0; end
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(iss_ready == 1'b1, "R1", iss_ready, 1);
    sweep("R1");

    // R2 / R3 chain of writers to register 2
    step(1, 2, 1, 0, 0, 0, '0, "R3");
    step(1, 2, 2, 0, 0, 0, '0, "R3");
    step(1, 2, 3, 0, 0, 0, '0, "R2");
    // R4 completion of a unit no longer named: register stays on unit 3
    step(0, 0, 0, 1, 2, 0, '0, "R4");
    // R7 rollback of unit 3 must not bring back completed unit 2
    step(0, 0, 0, 0, 0, 1, 8'b0000_1000, "R7");
    // R10 rollback of idle units
    step(1, 5, 4, 0, 0, 0, '0, "R3");
    step(0, 0, 0, 0, 0, 1, 8'b0110_0000, "R10");
    // R5 issue and completion together on the same register
    step(1, 5, 6, 1, 4, 0, '0, "R5");
    step(0, 0, 0, 0, 0, 1, 8'b0100_0000, "R5");
    // R6 nested rollback on one register
    step(1, 7, 0, 0, 0, 0, '0, "R6");
    step(1, 7, 2, 0, 0, 0, '0, "R6");
    step(1, 7, 5, 0, 0, 0, '0, "R6");
    step(0, 0, 0, 0, 0, 1, 8'b0010_0100, "R6");
    // R9 issue during rollback ignored, completion applied after restore
    step(1, 9, 3, 1, 0, 1, 8'b0000_0000, "R9");
    step(1, 9, 3, 0, 0, 0, '0, "R9");
    step(1, 9, 7, 0, 0, 0, '0, "R9");
    step(0, 0, 0, 1, 3, 1, 8'b1000_0000, "R9");
    // R8 fill the history and try one more
    for (int u = 0; u < NU; u++) if (!unit_busy(u)) step(1, u + 1, u, 0, 0, 0, '0, "R8");
    step(1, 12, 0, 0, 0, 0, '0, "R8");
    step(1, 12, 0, 1, 4, 0, '0, "R8");
    step(0, 0, 0, 0, 0, 1, 8'hff, "R6");

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      bit iv, cv, rv;
      int rg, un, cu;
      iv = ($urandom % 10) < 6;
      cv = ($urandom % 10) < 4;
      rv = ($urandom % 100) < 8;
      rg = $urandom % NR;
      un = $urandom % NU;
      for (int t = 0; t < NU && unit_busy(un); t++) un = (un + 1) % NU;
      if (unit_busy(un)) iv = 0;
      cu = $urandom % NU;
      if (r_cnt > 0 && ($urandom % 10) != 0) cu = r_tag[$urandom % r_cnt];
      mk = '0;
      if (($urandom % 4) == 0) mk = NU'($urandom);
      else if (r_cnt > 0) begin
        int k;
        k = 1 + ($urandom % r_cnt);
        for (int i = r_cnt - k; i < r_cnt; i++) mk[r_tag[i]] = 1'b1;
      end
      step(iv, rg, un, cv, cu, rv, mk, rv ? "R6" : (cv ? "R4" : "R3"));
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule